// File: doc/BRIEF.md
# Processor Clock and Standby Controller

This block turns an oscillator-derived clock into the machine-cycle enable that paces a small processor core. Software picks one of three cycle lengths (4, 8 or 64 input clocks) through a 4-bit control register written over a simple register bus. A speed change never cuts short the cycle that is already running: the new length applies from the next cycle boundary. A second enable, for the peripherals, is taken ahead of the speed selector and toggles on every input clock while the oscillator runs.

The block also holds the two standby states. A HALT strobe from the instruction decoder freezes the CPU enable while the peripherals keep their clock. A STOP strobe also drops the oscillator-enable line. A release from the interrupt controller ends either state. After STOP, the oscillator comes back first, and the CPU is held until the interval timer reports that the oscillator has settled. Entering or leaving standby clears the two upper control bits. Reset clears all standby state.

Top module: `pclk_standby_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the control register reads 0000, `oscEnable` is 1, `cpuCycleEn` is 0 during reset, and the enable then repeats every 64 clocks.
- R2: Control bits [1:0] choose the cycle length: 00 gives 64 clocks, 01 and 10 give 8, and 11 gives 4. Each `cpuCycleEn` pulse is one clock wide.
- R3: A new speed written in the clock after an enable pulse does not shorten or stretch the cycle in progress. That cycle completes at the old length, and the next cycle uses the new one.
- R4: After `haltReq` is taken, `cpuCycleEn` stays 0, `periphClkEn` toggles on every clock and `oscEnable` stays 1.
- R5: After `stopReq` is taken, `oscEnable` goes to 0 and `periphClkEn` holds its value. If `haltReq` and `stopReq` arrive together, STOP wins.
- R6: `intRelease` ends HALT. The first `cpuCycleEn` is seen N clocks after the edge that samples the release, where N is the selected cycle length.
- R7: `intRelease` ends STOP by raising `oscEnable` in the next clock. The CPU stays held until `settleRelease` arrives. A `settleRelease` that arrives while the oscillator is still off is ignored.
- R8: After `settleRelease` ends the post-STOP wait, the first `cpuCycleEn` comes N clocks later, where N is the selected cycle length.
- R9: Control bits [3:2] read back as written while running. They are cleared when standby is entered and when it is released. Bits [1:0] are kept in both cases.
- R10: While running, `intRelease` and `settleRelease` have no effect. A `haltReq` or `stopReq` that arrives during HALT, STOP or the settle wait is ignored.
- R11: Reset asserted during HALT or STOP returns the block to the running state with `oscEnable` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator clock |
| rstN | input | 1 | Active-low internal reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 4 | Control register write value |
| regRdData | output | 4 | Control register contents |
| haltReq | input | 1 | HALT instruction strobe |
| stopReq | input | 1 | STOP instruction strobe |
| intRelease | input | 1 | Standby release from the interrupt controller |
| settleRelease | input | 1 | Oscillator-settled release from the interval timer |
| cpuCycleEn | output | 1 | One-clock machine-cycle enable |
| periphClkEn | output | 1 | Peripheral clock enable, toggling every clock while the oscillator runs |
| oscEnable | output | 1 | Oscillator run enable |

## Verification
The bench writes a new speed exactly at a cycle boundary and counts clocks to the next enable. A design that switches speed mid-cycle would produce a 4-clock gap where 64 is expected. It measures the distance from a HALT release or a settle release to the first enable, which exposes a counter that is not reloaded during standby. It sends a settle release while the oscillator is still off, so a design that leaves the wait too early would start the CPU with no oscillator. It also sends stray strobes during standby and stray releases while running, and a design that acts on them would shift the period or lose the upper control bits.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int CTRL_W = 4;
  localparam int SPEED_W = 2;

  typedef enum logic [SPEED_W-1:0] {
    SPD_SLOW  = 2'b00,
    SPD_MIDA  = 2'b01,
    SPD_MIDB  = 2'b10,
    SPD_FAST  = 2'b11
  } speedSel_e;

  typedef struct packed {
    logic       cpuRun;
    logic       oscOn;
    speedSel_e  speed;
  } clkStrobes_t;
endpackage

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              haltReq,
  input  logic              stopReq,
  input  logic              intRelease,
  input  logic              settleRelease,
  output logic [CTRL_W-1:0] ctrlQ,
  output clkStrobes_t       strobes
);
  logic haltQ, stopQ, waitQ;
  logic idle, takeHalt, takeStop, wake, standbyEdge;
  logic [CTRL_W-1:0] ctrlNext;

  assign idle        = !haltQ && !stopQ && !waitQ;
  assign takeStop    = idle && stopReq;
  assign takeHalt    = idle && haltReq && !stopReq;
  assign wake        = intRelease && (haltQ || stopQ);
  assign standbyEdge = takeStop || takeHalt || wake;

  always_comb begin
    ctrlNext = ctrlQ;
    if (wrEn) ctrlNext = wrData;
    if (standbyEdge) ctrlNext[CTRL_W-1:SPEED_W] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      haltQ <= 1'b0;
      stopQ <= 1'b0;
      waitQ <= 1'b0;
    end else begin
      ctrlQ <= ctrlNext;
      if (takeHalt)  haltQ <= 1'b1;
      else if (wake) haltQ <= 1'b0;
      if (takeStop)  stopQ <= 1'b1;
      else if (wake) stopQ <= 1'b0;
      if (takeStop)  waitQ <= 1'b1;
      else if (settleRelease && waitQ && !stopQ) waitQ <= 1'b0;
    end
  end

  assign strobes.cpuRun = idle;
  assign strobes.oscOn  = !stopQ;
  assign strobes.speed  = speedSel_e'(ctrlQ[SPEED_W-1:0]);

  // R5
  stop_osc_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && idle) |=> !strobes.oscOn);
  // R7
  osc_stays_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.oscOn && !intRelease) |=> !strobes.oscOn);
  // R9
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && idle) |=> (ctrlQ[CTRL_W-1:SPEED_W] == '0));
  // R7
  early_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && settleRelease) |=> waitQ);
endmodule

// File: rtl/pclk_datapath.sv
module pclk_datapath
  import pclk_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  clkStrobes_t strobes,
  output logic        cpuCycleEn,
  output logic        periphClkEn
);
  localparam int CNT_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reloadVal;

  always_comb begin
    case (strobes.speed)
      SPD_SLOW: reloadVal = CNT_W'(DIV_SLOW - 1);
      SPD_FAST: reloadVal = CNT_W'(DIV_FAST - 1);
      default:  reloadVal = CNT_W'(DIV_MID - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_W'(DIV_SLOW - 1);
    end else if (!strobes.cpuRun || cnt == '0) begin
      cnt <= reloadVal;
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) periphClkEn <= 1'b0;
    else if (strobes.oscOn) periphClkEn <= !periphClkEn;
  end

  assign cpuCycleEn = strobes.cpuRun && (cnt == '0);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuCycleEn |=> !cpuCycleEn);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cpuRun && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R4
  periph_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.oscOn |=> (periphClkEn != $past(periphClkEn)));
  // R5
  periph_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.oscOn |=> $stable(periphClkEn));
endmodule

// File: rtl/pclk_standby_ctrl.sv
module pclk_standby_ctrl
  import pclk_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  output logic [CTRL_W-1:0] regRdData,
  input  logic              haltReq,
  input  logic              stopReq,
  input  logic              intRelease,
  input  logic              settleRelease,
  output logic              cpuCycleEn,
  output logic              periphClkEn,
  output logic              oscEnable
);
  clkStrobes_t strobes;

  pclk_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (regWrEn),
    .wrData        (regWrData),
    .haltReq       (haltReq),
    .stopReq       (stopReq),
    .intRelease    (intRelease),
    .settleRelease (settleRelease),
    .ctrlQ         (regRdData),
    .strobes       (strobes)
  );

  pclk_datapath #(
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cpuCycleEn  (cpuCycleEn),
    .periphClkEn (periphClkEn)
  );

  assign oscEnable = strobes.oscOn;
endmodule

// File: tb/pclk_standby_ctrl_tb.sv
module pclk_standby_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regWrData = '0;
  logic [3:0] regRdData;
  logic haltReq = 1'b0, stopReq = 1'b0, intRelease = 1'b0, settleRelease = 1'b0;
  logic cpuCycleEn, periphClkEn, oscEnable;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pclk_standby_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .haltReq(haltReq), .stopReq(stopReq),
    .intRelease(intRelease), .settleRelease(settleRelease),
    .cpuCycleEn(cpuCycleEn), .periphClkEn(periphClkEn), .oscEnable(oscEnable)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStrobes();
    regWrEn = 1'b0; haltReq = 1'b0; stopReq = 1'b0;
    intRelease = 1'b0; settleRelease = 1'b0;
  endtask

  // counts negedge samples until cpuCycleEn; clears strobes at the first one
  task automatic countToPulse(output int n);
    n = -1;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (k == 1) clearStrobes();
      if (cpuCycleEn) begin n = k; return; end
    end
  endtask

  task automatic measurePeriod(output int n);
    int dummy;
    countToPulse(dummy);
    countToPulse(n);
  endtask

  task automatic writeCtrl(input logic [3:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); clearStrobes();
  endtask

  task automatic t_reset();
    int per;
    chkEq("R1 cpu in reset", int'(cpuCycleEn), 0);
    chkEq("R1 osc in reset", int'(oscEnable), 1);
    chkEq("R1 ctrl in reset", int'(regRdData), 0);
    @(negedge clk); rstN = 1'b1;
    measurePeriod(per);
    chkEq("R1 reset period", per, 64);
  endtask

  task automatic t_speeds();
    int per;
    writeCtrl(4'h3); measurePeriod(per); measurePeriod(per); chkEq("R2 code 11", per, 4);
    writeCtrl(4'h1); measurePeriod(per); measurePeriod(per); chkEq("R2 code 01", per, 8);
    writeCtrl(4'h2); measurePeriod(per); measurePeriod(per); chkEq("R2 code 10", per, 8);
    writeCtrl(4'h0); measurePeriod(per); measurePeriod(per); chkEq("R2 code 00", per, 64);
  endtask

  task automatic t_boundary();
    int n, dummy;
    countToPulse(dummy);
    regWrEn = 1'b1; regWrData = 4'h3;
    countToPulse(n);
    chkEq("R3 slow cycle kept", n, 64);
    countToPulse(n);
    chkEq("R3 fast after boundary", n, 4);
    regWrEn = 1'b1; regWrData = 4'h0;
    countToPulse(n);
    chkEq("R3 fast cycle kept", n, 4);
    countToPulse(n);
    chkEq("R3 slow after boundary", n, 64);
  endtask

  task automatic t_halt();
    int n, pulses, toggles, oscLow;
    logic prev;
    writeCtrl(4'hF);
    chkEq("R9 upper bits readback", int'(regRdData), 15);
    @(negedge clk); haltReq = 1'b1;
    @(negedge clk); clearStrobes();
    chkEq("R9 cleared on halt entry", int'(regRdData), 3);
    pulses = 0; toggles = 0; oscLow = 0;
    for (int k = 0; k < 16; k++) begin
      prev = periphClkEn;
      @(negedge clk);
      if (cpuCycleEn) pulses++;
      if (periphClkEn != prev) toggles++;
      if (!oscEnable) oscLow++;
    end
    chkEq("R4 cpu held in halt", pulses, 0);
    chkEq("R4 periph toggles in halt", toggles, 16);
    chkEq("R4 osc on in halt", oscLow, 0);
    writeCtrl(4'hF);
    @(negedge clk); intRelease = 1'b1;
    countToPulse(n);
    chkEq("R6 halt release latency", n, 4);
    chkEq("R9 cleared on release", int'(regRdData), 3);
  endtask

  task automatic t_stop();
    int n, pulses, changes;
    logic prev;
    writeCtrl(4'h1);
    @(negedge clk); stopReq = 1'b1; haltReq = 1'b1;
    @(negedge clk); clearStrobes();
    chkEq("R5 osc off after stop", int'(oscEnable), 0);
    changes = 0; pulses = 0;
    for (int k = 0; k < 10; k++) begin
      prev = periphClkEn;
      @(negedge clk);
      if (periphClkEn != prev) changes++;
      if (cpuCycleEn) pulses++;
    end
    chkEq("R5 periph frozen", changes, 0);
    chkEq("R5 cpu held in stop", pulses, 0);
    @(negedge clk); settleRelease = 1'b1;
    @(negedge clk); clearStrobes();
    chkEq("R7 early settle ignored osc", int'(oscEnable), 0);
    @(negedge clk); intRelease = 1'b1;
    @(negedge clk); clearStrobes();
    chkEq("R7 osc back after release", int'(oscEnable), 1);
    pulses = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cpuCycleEn) pulses++;
    end
    chkEq("R7 cpu waits for settle", pulses, 0);
    @(negedge clk); settleRelease = 1'b1;
    countToPulse(n);
    chkEq("R8 settle release latency", n, 8);
    measurePeriod(n);
    chkEq("R8 period after stop", n, 8);
  endtask

  task automatic t_ignored();
    int n;
    writeCtrl(4'hF);
    @(negedge clk); intRelease = 1'b1; settleRelease = 1'b1;
    @(negedge clk); clearStrobes();
    chkEq("R10 releases ignored while running", int'(regRdData), 15);
    measurePeriod(n);
    chkEq("R10 period unchanged", n, 4);
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); clearStrobes();
    @(negedge clk); haltReq = 1'b1;
    @(negedge clk); clearStrobes();
    @(negedge clk); intRelease = 1'b1;
    @(negedge clk); clearStrobes();
    @(negedge clk); haltReq = 1'b1; stopReq = 1'b1;
    @(negedge clk); clearStrobes();
    chkEq("R10 stop during wait ignored", int'(oscEnable), 1);
    @(negedge clk); settleRelease = 1'b1;
    countToPulse(n);
    chkEq("R10 halt during standby ignored", n, 4);
    measurePeriod(n);
    chkEq("R10 running after wait", n, 4);
  endtask

  task automatic t_reset_standby();
    int n;
    @(negedge clk); haltReq = 1'b1;
    @(negedge clk); clearStrobes();
    rstN = 1'b0;
    @(negedge clk);
    chkEq("R11 ctrl cleared by reset", int'(regRdData), 0);
    rstN = 1'b1;
    measurePeriod(n);
    chkEq("R11 running after halt reset", n, 64);
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); clearStrobes();
    chkEq("R11 stop entered", int'(oscEnable), 0);
    rstN = 1'b0;
    @(negedge clk);
    chkEq("R11 osc on under reset", int'(oscEnable), 1);
    rstN = 1'b1;
    measurePeriod(n);
    chkEq("R11 running after stop reset", n, 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_speeds();
    t_boundary();
    t_halt();
    t_stop();
    t_ignored();
    t_reset_standby();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule